// File: doc/BRIEF.md
# Scaled Bitmap Character Plotter

This engine draws one character glyph onto a TFT panel through a byte-wide write port. A single start pulse carries an 8-bit character code, an 8-bit attribute word, a background colour and an erase flag. The engine first sends the memory-write command byte. It then walks the glyph row by row. For every glyph bit it sends a red, green, blue byte triplet, using the foreground colour for set bits and the background colour for clear bits.

The attribute word carries three fields. Its low nibble picks one of sixteen palette colours. Bits 6:4 give a replication factor that enlarges the glyph in both directions. Bit 7 chooses between an 8x8 font and a narrow 4-wide, 5-row font. Control codes fold onto the first glyph. The font store and the palette are modelled inside the block, so the block only needs a start pulse and then streams bytes, one per clock, until it finishes.

Top module: `glyph_plotter`

## Requirements
- R1: After reset, `busy`, `out_valid` and `done` are low.
- R2: A `start` pulse seen while `busy` is low is accepted. In the next cycle the block drives `out_valid` and `out_is_cmd` high with `out_byte` = 0x2C. This command byte appears only once per character. A `start` pulse seen while `busy` is high is ignored.
- R3: After the command, every pixel is sent as three consecutive bytes in the order red, green, blue, one byte per cycle, with `out_is_cmd` low.
- R4: Attribute bits 3:0 pick palette entry i. For each component, a base bit is taken from i[2] for red, i[1] for green and i[0] for blue. The component byte is 0xAA times that base bit, plus 0x55 times i[3].
- R5: Attribute bits 6:4 give a scale factor S from 1 to 7, and a field value of 0 acts as S = 1. Each glyph bit is sent S times in a row.
- R6: Each glyph row, with its horizontal replication, is sent S times in full before the next row starts.
- R7: Attribute bit 7 = 1 selects the 8-wide, 8-row font, which uses all bits of each row byte. Bit 7 = 0 selects the 4-wide, 5-row font, which uses row-byte bits 7:4.
- R8: Codes below 0x20 map to glyph g = 0. Any other code maps to g = code - 0x20. Row r of a glyph is read at address a = 8*g + r. In the 8x8 font the row byte is ((53*a + 0x3C) mod 256) XOR (floor(a/256)*32). In the narrow font it is ((29*a + 0x91) mod 256) AND 0xF0.
- R9: Row bits are used most significant bit first. A 1 bit sends the foreground colour and a 0 bit sends `bg_rgb`, with red in bits 23:16, green in 15:8 and blue in 7:0.
- R10: When `erase` is high at start, set bits also use the background colour, so every pixel byte equals the matching `bg_rgb` component.
- R11: Exactly 1 + 3*W*H*S*S bytes are sent. `busy` and `out_valid` stay high through the last byte. In the following cycle `busy` is low and `done` is high for exactly one cycle.
- R12: Code, attribute, erase flag and background are captured when start is accepted. Changes to these inputs while `busy` is high have no effect on the bytes sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to plot one character |
| char_code | input | 8 | Character code |
| attr | input | 8 | Colour index, scale and font select |
| erase | input | 1 | Draw set bits in the background colour |
| bg_rgb | input | 24 | Background colour {red, green, blue} |
| busy | output | 1 | Character in progress |
| done | output | 1 | One-cycle pulse after the last byte |
| out_valid | output | 1 | `out_byte` carries a byte this cycle |
| out_is_cmd | output | 1 | Current byte is the command byte |
| out_byte | output | 8 | Byte to the panel |

## Verification
On every cycle, the assertions check the start-to-command timing and that the command byte appears only once. They also check that the component index steps red to green to blue, that the last byte is followed by a single `done` pulse, that the scale stays within 1 to 7, and that erased characters carry only background bytes. Only the bench scenarios can show that the palette values, the font contents, the most-significant-bit-first order and the row and column replication produce the right byte stream. The same holds for the total byte count, for control-code folding, and for input changes during a character leaving the stream untouched. To show these, a behavioural model builds the expected stream and compares it byte by byte.

// File: rtl/glyph_pkg.sv
package glyph_pkg;

  localparam int          BYTE_W        = 8;
  localparam logic [7:0]  CMD_WRITE_MEM = 8'h2C;
  localparam logic [7:0]  FIRST_PRINT   = 8'h20;
  localparam int          PAL_ENTRIES   = 16;
  localparam int          PAL_STRIDE    = 4;
  localparam int          PAL_DEPTH     = PAL_ENTRIES * PAL_STRIDE;
  localparam int          PAL_AW        = $clog2(PAL_DEPTH);

  typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_PIX} seq_state_e;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;

  // control codes fold onto glyph zero
  function automatic logic [7:0] glyph_index(input logic [7:0] code);
    return (code < FIRST_PRINT) ? 8'h00 : code - FIRST_PRINT;
  endfunction

  // eight row slots per glyph
  function automatic logic [10:0] glyph_addr(input logic [7:0] g, input logic [2:0] row);
    return {g, row};
  endfunction

  function automatic logic [7:0] font_byte(input logic big, input logic [10:0] a);
    logic [7:0] mix;
    if (big) begin
      mix = a[7:0] * 8'd53 + 8'h3C;
      return mix ^ {a[10:8], 5'b00000};
    end else begin
      mix = a[7:0] * 8'd29 + 8'h91;
      return mix & 8'hF0;
    end
  endfunction

  // palette slot: entry index in the upper bits, component in the low two
  function automatic logic [PAL_AW-1:0] pal_addr(input logic [3:0] idx, input logic [1:0] comp);
    return {idx, comp};
  endfunction

  function automatic logic [7:0] pal_byte(input logic [PAL_AW-1:0] addr);
    logic base;
    logic [7:0] v;
    case (addr[1:0])
      2'd0:    base = addr[4];
      2'd1:    base = addr[3];
      2'd2:    base = addr[2];
      default: base = 1'b0;
    endcase
    v = 8'h00;
    if (base)    v = v + 8'hAA;
    if (addr[5]) v = v + 8'h55;
    if (addr[1:0] == 2'd3) v = 8'h00;
    return v;
  endfunction

endpackage

// File: rtl/glyph_attr_decode.sv
module glyph_attr_decode
  import glyph_pkg::*;
#(
  parameter int BIG_W   = 8,
  parameter int BIG_H   = 8,
  parameter int SMALL_W = 4,
  parameter int SMALL_H = 5
) (
  input  logic [7:0]  attr,
  input  logic        erase,
  input  rgb_t        bg,
  output rgb_t        fg_eff,
  output logic [2:0]  scale,
  output logic [3:0]  gw,
  output logic [3:0]  gh,
  output logic        big_font
);

  logic [7:0] pal_mem [PAL_DEPTH];
  rgb_t       pal_rgb;

  for (genvar i = 0; i < PAL_DEPTH; i++) begin : g_pal
    assign pal_mem[i] = pal_byte(PAL_AW'(i));
  end

  assign pal_rgb.r = pal_mem[pal_addr(attr[3:0], 2'd0)];
  assign pal_rgb.g = pal_mem[pal_addr(attr[3:0], 2'd1)];
  assign pal_rgb.b = pal_mem[pal_addr(attr[3:0], 2'd2)];

  assign fg_eff   = erase ? bg : pal_rgb;
  assign scale    = (attr[6:4] == 3'd0) ? 3'd1 : attr[6:4];
  assign big_font = attr[7];
  assign gw       = big_font ? 4'(BIG_W) : 4'(SMALL_W);
  assign gh       = big_font ? 4'(BIG_H) : 4'(SMALL_H);

endmodule

// File: rtl/glyph_row_fetch.sv
module glyph_row_fetch
  import glyph_pkg::*;
(
  input  logic       big_font,
  input  logic [7:0] char_code,
  input  logic [2:0] row,
  output logic [7:0] row_bits
);

  logic [7:0]  g;
  logic [10:0] a;

  assign g        = glyph_index(char_code);
  assign a        = glyph_addr(g, row);
  assign row_bits = font_byte(big_font, a);

endmodule

// File: rtl/glyph_seq.sv
module glyph_seq
  import glyph_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [3:0] gw,
  input  logic [3:0] gh,
  input  logic [2:0] scale,
  output seq_state_e state,
  output logic [3:0] row,
  output logic [3:0] col,
  output logic [1:0] comp,
  output logic       last_byte,
  output logic       done
);

  seq_state_e state_q;
  logic [3:0] row_q, col_q;
  logic [2:0] rrep_q, crep_q;
  logic [1:0] comp_q;
  logic       done_q;

  logic comp_end, crep_end, col_end, rrep_end, row_end, in_pix;

  assign in_pix    = (state_q == ST_PIX);
  assign comp_end  = (comp_q == 2'd2);
  assign crep_end  = (crep_q == scale - 3'd1);
  assign col_end   = (col_q  == gw - 4'd1);
  assign rrep_end  = (rrep_q == scale - 3'd1);
  assign row_end   = (row_q  == gh - 4'd1);
  assign last_byte = in_pix && comp_end && crep_end && col_end && rrep_end && row_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      col_q   <= '0;
      rrep_q  <= '0;
      crep_q  <= '0;
      comp_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_byte;
      case (state_q)
        ST_IDLE: begin
          if (go) begin
            state_q <= ST_CMD;
            row_q   <= '0;
            col_q   <= '0;
            rrep_q  <= '0;
            crep_q  <= '0;
            comp_q  <= '0;
          end
        end
        ST_CMD: state_q <= ST_PIX;
        ST_PIX: begin
          if (last_byte) state_q <= ST_IDLE;
          if (!comp_end) begin
            comp_q <= comp_q + 2'd1;
          end else begin
            comp_q <= '0;
            if (!crep_end) begin
              crep_q <= crep_q + 3'd1;
            end else begin
              crep_q <= '0;
              if (!col_end) begin
                col_q <= col_q + 4'd1;
              end else begin
                col_q <= '0;
                if (!rrep_end) begin
                  rrep_q <= rrep_q + 3'd1;
                end else begin
                  rrep_q <= '0;
                  row_q  <= row_q + 4'd1;
                end
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state = state_q;
  assign row   = row_q;
  assign col   = col_q;
  assign comp  = comp_q;
  assign done  = done_q;

endmodule

// File: rtl/glyph_plotter.sv
module glyph_plotter
  import glyph_pkg::*;
#(
  parameter int BIG_W   = 8,
  parameter int BIG_H   = 8,
  parameter int SMALL_W = 4,
  parameter int SMALL_H = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  char_code,
  input  logic [7:0]  attr,
  input  logic        erase,
  input  logic [23:0] bg_rgb,
  output logic        busy,
  output logic        done,
  output logic        out_valid,
  output logic        out_is_cmd,
  output logic [7:0]  out_byte
);

  logic [7:0] code_q, attr_q;
  logic       erase_q;
  rgb_t       bg_q;
  logic       accept;

  rgb_t       fg_w, trip_w;
  logic [2:0] scale_w;
  logic [3:0] gw_w, gh_w;
  logic       big_w;
  logic [7:0] row_bits_w;
  seq_state_e state_w;
  logic [3:0] row_w, col_w;
  logic [1:0] comp_w;
  logic       last_byte_w;
  logic       pix_bit_w;
  logic [7:0] pix_byte_w;

  assign accept = start && (state_w == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q  <= '0;
      attr_q  <= 8'h10;
      erase_q <= 1'b0;
      bg_q    <= '0;
    end else if (accept) begin
      code_q  <= char_code;
      attr_q  <= attr;
      erase_q <= erase;
      bg_q    <= bg_rgb;
    end
  end

  glyph_attr_decode #(
    .BIG_W(BIG_W), .BIG_H(BIG_H), .SMALL_W(SMALL_W), .SMALL_H(SMALL_H)
  ) u_dec (
    .attr(attr_q), .erase(erase_q), .bg(bg_q),
    .fg_eff(fg_w), .scale(scale_w), .gw(gw_w), .gh(gh_w), .big_font(big_w)
  );

  glyph_row_fetch u_rom (
    .big_font(big_w), .char_code(code_q), .row(row_w[2:0]), .row_bits(row_bits_w)
  );

  glyph_seq u_seq (
    .clk(clk), .rst_n(rst_n), .go(accept),
    .gw(gw_w), .gh(gh_w), .scale(scale_w),
    .state(state_w), .row(row_w), .col(col_w), .comp(comp_w),
    .last_byte(last_byte_w), .done(done)
  );

  assign pix_bit_w = row_bits_w[3'd7 - col_w[2:0]];
  assign trip_w    = pix_bit_w ? fg_w : bg_q;

  always_comb begin
    case (comp_w)
      2'd0:    pix_byte_w = trip_w.r;
      2'd1:    pix_byte_w = trip_w.g;
      default: pix_byte_w = trip_w.b;
    endcase
  end

  assign busy       = (state_w != ST_IDLE);
  assign out_valid  = busy;
  assign out_is_cmd = (state_w == ST_CMD);
  assign out_byte   = (state_w == ST_CMD) ? CMD_WRITE_MEM :
                      (state_w == ST_PIX) ? pix_byte_w : 8'h00;

endmodule

// File: rtl/glyph_plotter_chk.sv
module glyph_plotter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        out_valid,
  input logic        out_is_cmd,
  input logic [7:0]  out_byte,
  input logic        last_byte,
  input logic        erase_q,
  input logic [1:0]  comp,
  input logic [23:0] bg_q,
  input logic [2:0]  scale
);

  logic [7:0] bg_sel;
  assign bg_sel = (comp == 2'd0) ? bg_q[23:16] : (comp == 2'd1) ? bg_q[15:8] : bg_q[7:0];

  p_start_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (out_valid && out_is_cmd && out_byte == 8'h2C));

  p_cmd_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_is_cmd |=> (out_valid && !out_is_cmd));

  p_rgb_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_is_cmd && comp != 2'd2) |=> (out_valid && comp == $past(comp) + 2'd1));

  p_scale_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (scale != 3'd0));

  p_erase_bg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_is_cmd && erase_q) |-> (out_byte == bg_sel));

  p_last_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    last_byte |=> (done && !busy));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_valid_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == busy);

endmodule

bind glyph_plotter glyph_plotter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .out_valid(out_valid), .out_is_cmd(out_is_cmd), .out_byte(out_byte),
  .last_byte(last_byte_w), .erase_q(erase_q), .comp(comp_w),
  .bg_q(bg_q), .scale(scale_w)
);

// File: tb/test_glyph_plotter.sv
module test_glyph_plotter;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  char_code = '0;
  logic [7:0]  attr = '0;
  logic        erase = 1'b0;
  logic [23:0] bg_rgb = '0;
  logic        busy, done, out_valid, out_is_cmd;
  logic [7:0]  out_byte;

  int errors = 0;
  int checks = 0;
  int q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  glyph_plotter i_glyph_plotter (
    .clk(clk), .rst_n(rst_n), .start(start), .char_code(char_code), .attr(attr),
    .erase(erase), .bg_rgb(bg_rgb), .busy(busy), .done(done),
    .out_valid(out_valid), .out_is_cmd(out_is_cmd), .out_byte(out_byte)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int pal_b(int idx, int k);
    int base;
    base = (k == 0) ? (idx / 4) % 2 : (k == 1) ? (idx / 2) % 2 : idx % 2;
    return base * 170 + ((idx / 8) % 2) * 85;
  endfunction

  function automatic int rom_b(int big, int a);
    if (big != 0) return ((a * 53 + 60) % 256) ^ ((a / 256) * 32);
    return ((a * 29 + 145) % 256) & 240;
  endfunction

  function automatic int bg_b(int bg, int k);
    return (bg >> (16 - 8 * k)) & 255;
  endfunction

  // reference stream: bit 8 marks the command byte
  task automatic build(input int code, input int at, input int er, input int bg);
    int g, big, w, h, s, idx, rb, b, fgv, bgv;
    q.delete();
    g   = (code < 32) ? 0 : code - 32;
    big = (at / 128) % 2;
    w   = big ? 8 : 4;
    h   = big ? 8 : 5;
    s   = (at / 16) % 8;
    if (s == 0) s = 1;
    idx = at % 16;
    q.push_back(256 + 44);
    for (int r = 0; r < h; r++)
      for (int rr = 0; rr < s; rr++) begin
        rb = rom_b(big, g * 8 + r);
        for (int c = 0; c < w; c++) begin
          b = (rb >> (7 - c)) % 2;
          for (int cc = 0; cc < s; cc++)
            for (int k = 0; k < 3; k++) begin
              bgv = bg_b(bg, k);
              fgv = er ? bgv : pal_b(idx, k);
              q.push_back(b ? fgv : bgv);
            end
        end
      end
  endtask

  task automatic run(input int code, input int at, input int er, input int bg,
                     input bit inject, input string tag);
    int n, total, e;
    build(code, at, er, bg);
    total = q.size();
    @(negedge clk);
    char_code = 8'(code); attr = 8'(at); erase = er[0]; bg_rgb = 24'(bg);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (q.size() > 0) begin
      e = q.pop_front();
      chk(out_valid && busy, {tag, " R11 busy/valid"}, {busy, out_valid}, 3);
      chk(out_is_cmd == (e >= 256), {tag, " R2 cmd flag"}, out_is_cmd, e >= 256);
      chk(out_byte == 8'(e), {tag, " R3/R9 byte"}, out_byte, e % 256);
      n++;
      if (inject && n == 4) begin
        // R12: new inputs and start while busy must not disturb the stream
        start = 1'b1; char_code = 8'h55; attr = 8'h01; erase = ~erase; bg_rgb = 24'hFFFFFF;
      end else if (inject && n == 5) begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    chk(n == total, {tag, " R11 count"}, n, total);
    chk(done && !busy && !out_valid, {tag, " R11 done"}, {done, busy, out_valid}, 4);
    @(negedge clk);
    chk(!done && !busy, {tag, " R11 done pulse"}, {done, busy}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !out_valid && !done, "R1 reset", {busy, out_valid, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !out_valid && !done, "R1 idle", {busy, out_valid, done}, 0);
    run(8'h41, 8'h9C, 0, 24'h102030, 0, "R7 big s1");
    run(8'h7A, 8'h35, 0, 24'h0A0B0C, 0, "R5 R6 small s3");
    run(8'h10, 8'h8A, 0, 24'h000000, 0, "R8 ctrl s0");
    run(8'h20, 8'h8A, 0, 24'h000000, 0, "R8 space");
    run(8'h20, 8'hF3, 1, 24'h123456, 0, "R10 erase s7");
    run(8'hFF, 8'hA7, 0, 24'h405060, 1, "R12 inject");
    run(8'h1F, 8'h7F, 0, 24'h778899, 0, "R4 small s7");
    run(8'h5A, 8'hD8, 0, 24'h010203, 0, "R9 big s5");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule